// File: doc/BRIEF.md
# Reset Release Synchronizer

This block turns an asynchronous reset request into a reset for one destination clock domain. When the request goes high, the output goes high at once, with no clock edge needed. When the request goes low, the output stays high until a chain of flops has been loaded with zeros on the destination clock. It then falls in step with that clock.

The output is active-high. It is meant to drive the asynchronous reset pins of every register in the domain. Because the release is aligned to a clock edge, all of those registers leave reset on the same edge. The chain length is a parameter.

Each stage of the chain is a flop that the request presets to one. The first stage loads a constant zero. Every later stage loads the stage before it. The output is the last stage.

Top module: `rst_release_sync`

## Requirements
- R1: When `rstAsyncIn` rises at any point within a clock period, `rstSyncOut` is 1 within the same period, before the next rising edge of `clk`.
- R2: While `rstAsyncIn` is held at 1, `rstSyncOut` stays at 1 on every clock cycle.
- R3: If `rstAsyncIn` falls between two rising edges, `rstSyncOut` stays at 1 through the first DEPTH-1 rising edges that follow. It becomes 0 on the DEPTH-th rising edge.
- R4: The fall of `rstSyncOut` is aligned to a rising edge of `clk`. Just before the DEPTH-th edge it is still 1, and just after that edge it is 0.
- R5: Once `rstSyncOut` is 0, it stays at 0 for as long as `rstAsyncIn` stays at 0.
- R6: If `rstAsyncIn` rises again before the release has finished, `rstSyncOut` goes back to (or stays at) 1 at once. After the next fall of the input, the full count of DEPTH edges starts again.
- R7: The parameter DEPTH sets the number of chain stages, with a default of 2 and a minimum of 2. The output is taken from the last stage.
- R8: A pulse on `rstAsyncIn` that is shorter than one clock period and lies between two edges still raises `rstSyncOut`. The output then holds 1 for the full DEPTH edges after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Destination domain clock |
| rstAsyncIn | input | 1 | Asynchronous reset request, active high |
| rstSyncOut | output | 1 | Domain reset, high at once when requested, released on a clock edge |

## Verification
On every clock edge, the assertions check two things. The output must be high whenever the request is high. The output must also match an edge count kept since the last release: it stays high until DEPTH edges have been counted, and it stays low after that.

Some behaviour happens between clock edges, and only the bench's directed scenarios can show it. These are the immediate rise of the output at random points within a cycle, a short request pulse that no edge ever samples, and the exact position of the fall relative to the DEPTH-th edge.

// File: rtl/rst_release_sync_pkg.sv
package rst_release_sync_pkg;

  // Shortest chain that still gives a settling stage before the output.
  localparam int MIN_DEPTH = 2;

  // Strobes passed from the control module to the flop chain.
  typedef struct packed {
    logic presetAll;   // async force of every stage to one
    logic seedBit;     // value loaded into the first stage on each edge
  } syncStrobe_t;

endpackage

// File: rtl/rst_release_sync_ctrl.sv
module rst_release_sync_ctrl
  import rst_release_sync_pkg::*;
(
  input  logic        rstAsyncIn,
  output syncStrobe_t strobes
);

  // The request presets the whole chain. The first stage always loads zero,
  // so the release travels down the chain one edge per stage.
  always_comb begin
    strobes.presetAll = rstAsyncIn;
    strobes.seedBit   = 1'b0;
  end

endmodule

// File: rtl/rst_release_sync_chain.sv
module rst_release_sync_chain
  import rst_release_sync_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic        clk,
  input  syncStrobe_t strobes,
  output logic        lastStage
);

  localparam int LAST_IDX = DEPTH - 1;

  logic             presetLine;
  logic             seedLine;
  logic [DEPTH-1:0] stageD;
  logic [DEPTH-1:0] stageQ;

  assign presetLine = strobes.presetAll;
  assign seedLine   = strobes.seedBit;

  generate
    if (DEPTH < MIN_DEPTH) begin : g_bad_depth
      $error("rst_release_sync_chain: DEPTH must be at least 2");
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign stageD[i] = seedLine;
      end else begin : g_body
        assign stageD[i] = stageQ[i-1];
      end

      always_ff @(posedge clk or posedge presetLine) begin
        if (presetLine) stageQ[i] <= 1'b1;
        else            stageQ[i] <= stageD[i];
      end
    end
  endgenerate

  assign lastStage = stageQ[LAST_IDX];

endmodule

// File: rtl/rst_release_sync.sv
module rst_release_sync
  import rst_release_sync_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rstAsyncIn,
  output logic rstSyncOut
);

  syncStrobe_t strobes;

  rst_release_sync_ctrl ctrl_i (
    .rstAsyncIn (rstAsyncIn),
    .strobes    (strobes)
  );

  rst_release_sync_chain #(.DEPTH(DEPTH)) chain_i (
    .clk       (clk),
    .strobes   (strobes),
    .lastStage (rstSyncOut)
  );

endmodule

// File: rtl/rst_release_sync_chk.sv
module rst_release_sync_chk #(
  parameter int DEPTH = 2
) (
  input logic clk,
  input logic rstAsyncIn,
  input logic rstSyncOut
);

  localparam int CW = $clog2(DEPTH + 1);

  // Rising edges seen since the last release. Saturates at DEPTH.
  logic [CW-1:0] relCnt;

  always_ff @(posedge clk or posedge rstAsyncIn) begin
    if (rstAsyncIn)                  relCnt <= '0;
    else if (relCnt != CW'(DEPTH))   relCnt <= relCnt + 1'b1;
  end

  // R1: sampled between edges, a high request always shows a high output.
  always @(negedge clk) begin
    if (rstAsyncIn) a_r1_high_between_edges: assert (rstSyncOut);
  end

  // R2: at each edge, a held request keeps the output high.
  always @(posedge clk) begin
    if (rstAsyncIn) a_r2_hold_while_requested: assert (rstSyncOut);
  end

  // R3: before DEPTH edges since release, the output is still high.
  a_r3_hold_until_depth: assert property (@(posedge clk) disable iff (rstAsyncIn)
    (relCnt < CW'(DEPTH)) |-> rstSyncOut);

  // R5: after DEPTH edges since release, the output is low and stays low.
  a_r5_stay_released: assert property (@(posedge clk) disable iff (rstAsyncIn)
    (relCnt == CW'(DEPTH)) |-> !rstSyncOut);

endmodule

bind rst_release_sync rst_release_sync_chk #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rstAsyncIn (rstAsyncIn),
  .rstSyncOut (rstSyncOut)
);

// File: tb/rst_release_sync_tb_top.sv
`timescale 1ns/100ps
module rst_release_sync_tb_top;

  localparam int DEPTH_TB = 2;

  logic clk = 1'b0;
  logic rstAsyncIn;
  logic rstSyncOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rst_release_sync #(.DEPTH(DEPTH_TB)) dut_i (
    .clk        (clk),
    .rstAsyncIn (rstAsyncIn),
    .rstSyncOut (rstSyncOut)
  );

  task automatic check(input string req, input logic exp, input string what);
    nChecks++;
    if (rstSyncOut !== exp) begin
      nFails++;
      $display("FAIL %s %s: rstSyncOut actual=%b expected=%b at %0t",
               req, what, rstSyncOut, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // Drop the request at a point off the edge, then count edges.
  // Before edge DEPTH the output is high. Just after that edge it is low.
  task automatic releaseAndCount(input string req, input int offs);
    @(posedge clk); #(offs);
    rstAsyncIn = 1'b0;
    #0.5 check(req, 1'b1, "right after release");
    for (int k = 1; k <= DEPTH_TB; k++) begin
      @(posedge clk); #1;
      check(req, (k < DEPTH_TB) ? 1'b1 : 1'b0, $sformatf("after edge %0d", k));
    end
  endtask

  // R7: the output starts high while the request is high.
  task automatic tResetState();
    repeat (3) @(posedge clk);
    #2 check("R7", 1'b1, "reset state");
  endtask

  // R2: the request is held high for several cycles.
  task automatic tHoldHigh();
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #3;
      check("R2", 1'b1, "held request");
    end
  endtask

  // R3 and R4: release at random offsets, and check both sides of edge DEPTH.
  task automatic tReleaseTiming(input int offs);
    @(posedge clk); #(offs);
    rstAsyncIn = 1'b0;
    for (int k = 1; k < DEPTH_TB; k++) begin
      @(posedge clk); #1;
      check("R3", 1'b1, $sformatf("edge %0d of release", k));
    end
    @(negedge clk); #3;
    check("R4", 1'b1, "just before final edge");
    @(posedge clk); #0.5;
    check("R4", 1'b0, "just after final edge");
  endtask

  // R5: stays low while the request stays low.
  task automatic tStayLow();
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #2;
      check("R5", 1'b0, "steady released");
    end
  endtask

  // R1: assert at a random point within a cycle. The output is high before the next edge.
  task automatic tImmediateAssert(input int offs);
    @(posedge clk); #(offs);
    rstAsyncIn = 1'b1;
    #0.5 check("R1", 1'b1, $sformatf("immediate at offset %0d", offs));
  endtask

  // R6: re-request during the release, then a full recount.
  task automatic tReassertMid();
    @(posedge clk); #2;
    rstAsyncIn = 1'b0;
    @(posedge clk); #2;
    rstAsyncIn = 1'b1;
    #0.5 check("R6", 1'b1, "re-request mid release");
    releaseAndCount("R6", 3);
  endtask

  // R8: a short pulse between edges.
  task automatic tGlitch();
    @(posedge clk); #2;
    rstAsyncIn = 1'b1;
    #1 check("R8", 1'b1, "short pulse seen");
    rstAsyncIn = 1'b0;
    #1 check("R8", 1'b1, "held after short pulse");
    for (int k = 1; k <= DEPTH_TB; k++) begin
      @(posedge clk); #1;
      check("R8", (k < DEPTH_TB) ? 1'b1 : 1'b0, $sformatf("pulse release edge %0d", k));
    end
  endtask

  initial begin
    rstAsyncIn = 1'b1;
    tResetState();
    tHoldHigh();
    tReleaseTiming(1);
    tStayLow();
    for (int n = 0; n < 6; n++) begin
      tImmediateAssert(int'($urandom_range(1, 6)));
      tHoldHigh();
      tReleaseTiming(int'($urandom_range(1, 6)));
      tStayLow();
    end
    tImmediateAssert(5);
    tReassertMid();
    tStayLow();
    tGlitch();
    tStayLow();
    finishRun();
  end

  initial begin
    #(200000 * 8);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finishRun();
  end

endmodule